// File: doc/BRIEF.md
# Bank-Sliced Crosspoint Snooping Cache

This block is one cache slice placed at the crossing of a single processor's private bus and the shared bus of one memory bank. A processor sees a set of these slices, one per bank, that together behave like one larger direct-mapped cache. Each slice answers only for the addresses that belong to its own bank. Because no other requester uses that processor port, the port needs no arbitration. The level above this slice writes through, so every processor store arrives here.

The slice holds a direct-mapped store of tags, valid bits and line data. A read that hits answers on the next cycle. A read that misses asks the bank bus arbiter for the bus. Once granted, it drives one address cycle with the line-aligned address, takes four data beats from memory, marks the line valid and only then returns the requested word. Every write is passed to memory as one single-word bus write. A write that hits also updates the stored line. A write that misses does not allocate a line.

The slice also watches every transaction on its bank bus. A write made by another slice to a line held here clears that line's valid bit. Later readers of that line then fetch the fresh copy from memory.

Top module: `xp_cache_slice`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is high, and `cpu_rvalid` and `mb_req` are low. The first read of any address therefore misses.
- R2: A request is taken only when address bits [5:4] equal the `BANK_ID` parameter. A request for another bank produces no response, no bus request and no change in stored state, and `cpu_ready` stays high.
- R3: On a read miss the slice raises `mb_req`. After `mb_gnt` it drives exactly one cycle of `mb_valid` with `mb_we` low and `mb_addr` equal to the request address with bits [3:0] cleared.
- R4: The fill takes four `mb_rvalid` beats, which are stored as words 0 to 3 of the line in that order. The line is then marked valid, `mb_req` drops, and `cpu_rvalid` pulses for one cycle carrying the word selected by address bits [3:2].
- R5: A read hit raises `cpu_rvalid` for one cycle, in the cycle after the request is taken, with no bus request.
- R6: Every write to the slice's bank raises `mb_req`. After the grant it drives one cycle of `mb_valid` with `mb_we` high, `mb_addr` equal to the write address with bits [1:0] cleared, and `mb_wdata` equal to the written data.
- R7: A write hit updates the stored word. A later read of that word hits and returns the new data. The slice's own bus write does not invalidate its own line.
- R8: A write miss does not allocate a line, so a later read of that address misses and fetches the line.
- R9: A write seen on the snoop inputs while the slice does not own the bus clears the valid bit of the line at the same index if the tag matches. A snooped write with a different tag leaves the line valid.
- R10: The line index is taken from address bits [15:6] and the tag from bits [31:16]. Two addresses with the same index and different tags replace each other.
- R11: `cpu_ready` stays low from the cycle after a request is taken until the transaction ends, including the whole time `mb_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Slice can take a request this cycle |
| cpu_rvalid | output | 1 | Read data valid, one-cycle pulse |
| cpu_rdata | output | 32 | Read data |
| mb_req | output | 1 | Bus request to the bank arbiter |
| mb_gnt | input | 1 | Bus grant from the arbiter |
| mb_valid | output | 1 | Address cycle driven by this slice |
| mb_we | output | 1 | Address cycle is a write |
| mb_addr | output | 32 | Bus address |
| mb_wdata | output | 32 | Bus write data |
| mb_rvalid | input | 1 | Memory data beat valid |
| mb_rdata | input | 32 | Memory data beat |
| sn_valid | input | 1 | Observed bank bus cycle valid |
| sn_we | input | 1 | Observed cycle is a write |
| sn_addr | input | 32 | Observed cycle address |

## Verification
The bench targets several corner cases, each with a distinct failure signature.
- A write miss: a slice that allocated on it would return the write data on the next read without touching the bus.
- A write hit followed by a read: a slice that invalidated itself on its own mirrored bus write would miss when it should hit.
- Two snooped writes: one with a different tag must leave the line alone, and one with the matching tag must force a refetch. The refetch then returns the other slice's data.
- A request for a foreign bank: it must leave no trace on either bus.
- A same-index conflict: it must evict the earlier tag.
- Fill order: it is checked by reading the last word of a freshly filled line.

// File: rtl/xp_pkg.sv
// Shared types of the crosspoint cache slice.
// Assumes: nothing beyond standard SystemVerilog.
package xp_pkg;

    // Controller states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESP,
        ST_MISS_ARB,
        ST_MISS_ADDR,
        ST_MISS_FILL,
        ST_WR_ARB,
        ST_WR_ADDR
    } xp_state_e;

endpackage

// File: rtl/xp_addr_split.sv
// Cuts a byte address into word, bank, index and tag fields.
// Assumes: fields are contiguous, word lowest, tag highest.
module xp_addr_split #(
    parameter int ADDR_W  = 32,
    parameter int WORD_LO = 2,
    parameter int WORD_W  = 2,
    parameter int BANK_LO = 4,
    parameter int BANK_W  = 2,
    parameter int IDX_LO  = 6,
    parameter int IDX_W   = 10,
    parameter int TAG_LO  = 16,
    parameter int TAG_W   = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word,
    output logic [BANK_W-1:0] bank,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    logic unused_byte_bits;

    // Field extraction.
    always_comb begin
        word             = addr[WORD_LO +: WORD_W];
        bank             = addr[BANK_LO +: BANK_W];
        idx              = addr[IDX_LO  +: IDX_W];
        tag              = addr[TAG_LO  +: TAG_W];
        unused_byte_bits = ^addr[WORD_LO-1:0];
    end

endmodule

// File: rtl/xp_tag_array.sv
// Valid bits and tags of a direct-mapped store.
// One lookup port, one snoop-invalidate port and one fill port.
// Assumes: fill and snoop never target the same line in one cycle.
// If they do, the fill wins.
module xp_tag_array #(
    parameter int NUM_LINES = 1024,
    parameter int IDX_W     = 10,
    parameter int TAG_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             sn_en,
    input  logic [IDX_W-1:0] sn_idx,
    input  logic [TAG_W-1:0] sn_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];
    logic                 sn_match;

    // Lookup and snoop compare.
    always_comb begin
        lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        sn_match = sn_en && valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag);
    end

    // Valid bits: cleared by reset and by snoop, set by fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (sn_match) valid_q[sn_idx] <= 1'b0;
            if (fill_en)  valid_q[fill_idx] <= 1'b1;
        end
    end

    // Tags: written on fill only.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx] <= fill_tag;
    end

endmodule

// File: rtl/xp_line_ram.sv
// Line data store, one write port and one asynchronous read port.
// Assumes: addressed by line index and word within line.
module xp_line_ram #(
    parameter int NUM_LINES = 1024,
    parameter int WORDS     = 4,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 10,
    parameter int WORD_W    = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = NUM_LINES * WORDS;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{wr_idx, wr_word}] <= wr_data;
    end

    // Read port.
    always_comb begin
        rd_data = mem_q[{rd_idx, rd_word}];
    end

endmodule

// File: rtl/xp_slice_ctrl.sv
// Request controller of the slice. It takes processor requests,
// answers hits, and runs line fills and write-through bus writes.
// Assumes: the grant stays high while mb_req is high. Fill beats
// arrive only after the address cycle.
module xp_slice_ctrl
    import xp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int WORDS   = 4,
    parameter int WORD_LO = 2,
    parameter int WORD_W  = 2,
    parameter int IDX_LO  = 6,
    parameter int IDX_W   = 10,
    parameter int TAG_LO  = 16,
    parameter int TAG_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              bank_hit,
    input  logic              lk_hit,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    input  logic              mb_gnt,
    input  logic              mb_rvalid,
    input  logic [DATA_W-1:0] mb_rdata,
    output logic              mb_req,
    output logic              mb_valid,
    output logic              mb_we,
    output logic [ADDR_W-1:0] mb_addr,
    output logic [DATA_W-1:0] mb_wdata,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_widx,
    output logic [WORD_W-1:0] ram_wword,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              fill_en,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag
);

    localparam int               LINE_OFF  = WORD_LO + WORD_W;
    localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << LINE_OFF;
    localparam logic [ADDR_W-1:0] WORD_MASK = {ADDR_W{1'b1}} << WORD_LO;
    localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);

    xp_state_e         state_q, state_d;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [DATA_W-1:0] lat_wdata_q;
    logic [WORD_W-1:0] beat_q;
    logic              accept;
    logic              last_beat;

    // Request acceptance and beat tracking.
    always_comb begin
        accept    = (state_q == ST_IDLE) && cpu_req && bank_hit;
        last_beat = (state_q == ST_MISS_FILL) && mb_rvalid && (beat_q == LAST_BEAT);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cpu_we)      state_d = ST_WR_ARB;
                    else if (lk_hit) state_d = ST_RESP;
                    else             state_d = ST_MISS_ARB;
                end
            end
            ST_RESP:      state_d = ST_IDLE;
            ST_MISS_ARB:  if (mb_gnt) state_d = ST_MISS_ADDR;
            ST_MISS_ADDR: state_d = ST_MISS_FILL;
            ST_MISS_FILL: if (last_beat) state_d = ST_RESP;
            ST_WR_ARB:    if (mb_gnt) state_d = ST_WR_ADDR;
            ST_WR_ADDR:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State, latched request and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lat_addr_q  <= '0;
            lat_wdata_q <= '0;
            beat_q      <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                lat_addr_q  <= cpu_addr;
                lat_wdata_q <= cpu_wdata;
                beat_q      <= '0;
            end else if ((state_q == ST_MISS_FILL) && mb_rvalid) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Port-side and bus-side outputs.
    always_comb begin
        cpu_ready  = (state_q == ST_IDLE);
        cpu_rvalid = (state_q == ST_RESP);
        mb_req     = (state_q == ST_MISS_ARB) || (state_q == ST_MISS_ADDR) ||
                     (state_q == ST_MISS_FILL) || (state_q == ST_WR_ARB) ||
                     (state_q == ST_WR_ADDR);
        mb_valid   = (state_q == ST_MISS_ADDR) || (state_q == ST_WR_ADDR);
        mb_we      = (state_q == ST_WR_ADDR);
        mb_addr    = '0;
        mb_wdata   = '0;
        if (state_q == ST_MISS_ADDR) mb_addr = lat_addr_q & LINE_MASK;
        if (state_q == ST_WR_ADDR) begin
            mb_addr  = lat_addr_q & WORD_MASK;
            mb_wdata = lat_wdata_q;
        end
    end

    // Data store write port: write hit update or fill beat.
    always_comb begin
        ram_we    = 1'b0;
        ram_widx  = cpu_addr[IDX_LO +: IDX_W];
        ram_wword = cpu_addr[WORD_LO +: WORD_W];
        ram_wdata = cpu_wdata;
        if (accept && cpu_we && lk_hit) begin
            ram_we = 1'b1;
        end else if ((state_q == ST_MISS_FILL) && mb_rvalid) begin
            ram_we    = 1'b1;
            ram_widx  = lat_addr_q[IDX_LO +: IDX_W];
            ram_wword = beat_q;
            ram_wdata = mb_rdata;
        end
    end

    // Response read address and tag fill.
    always_comb begin
        rd_idx   = lat_addr_q[IDX_LO +: IDX_W];
        rd_word  = lat_addr_q[WORD_LO +: WORD_W];
        fill_en  = last_beat;
        fill_idx = lat_addr_q[IDX_LO +: IDX_W];
        fill_tag = lat_addr_q[TAG_LO +: TAG_W];
    end

endmodule

// File: rtl/xp_cache_slice.sv
// Crosspoint cache slice: a direct-mapped, write-through, snooping
// cache serving one processor for one memory bank.
// Assumes: the upper level writes through, and the snoop inputs
// mirror every cycle on the bank bus, this slice's own included.
module xp_cache_slice
    import xp_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int WORDS_PER_LINE = 4,
    parameter int NUM_BANKS      = 4,
    parameter int NUM_LINES      = 1024,
    parameter int BANK_ID        = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mb_req,
    input  logic              mb_gnt,
    output logic              mb_valid,
    output logic              mb_we,
    output logic [ADDR_W-1:0] mb_addr,
    output logic [DATA_W-1:0] mb_wdata,
    input  logic              mb_rvalid,
    input  logic [DATA_W-1:0] mb_rdata,
    input  logic              sn_valid,
    input  logic              sn_we,
    input  logic [ADDR_W-1:0] sn_addr
);

    localparam int OFF_W   = $clog2(DATA_W / 8);
    localparam int WORD_W  = $clog2(WORDS_PER_LINE);
    localparam int BANK_W  = $clog2(NUM_BANKS);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int WORD_LO = OFF_W;
    localparam int BANK_LO = WORD_LO + WORD_W;
    localparam int IDX_LO  = BANK_LO + BANK_W;
    localparam int TAG_LO  = IDX_LO + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LO;
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

    logic [WORD_W-1:0] c_word, s_word;
    logic [BANK_W-1:0] c_bank, s_bank;
    logic [IDX_W-1:0]  c_idx,  s_idx;
    logic [TAG_W-1:0]  c_tag,  s_tag;
    logic              lk_hit, sn_en, bank_hit;
    logic              ram_we, fill_en;
    logic [IDX_W-1:0]  ram_widx, rd_idx, fill_idx;
    logic [WORD_W-1:0] ram_wword, rd_word;
    logic [DATA_W-1:0] ram_wdata, rd_data;
    logic [TAG_W-1:0]  fill_tag;
    logic              unused_snoop_word;

    xp_addr_split #(
        .ADDR_W(ADDR_W), .WORD_LO(WORD_LO), .WORD_W(WORD_W), .BANK_LO(BANK_LO),
        .BANK_W(BANK_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_LO(TAG_LO), .TAG_W(TAG_W)
    ) u_cpu_split (
        .addr(cpu_addr), .word(c_word), .bank(c_bank), .idx(c_idx), .tag(c_tag)
    );

    xp_addr_split #(
        .ADDR_W(ADDR_W), .WORD_LO(WORD_LO), .WORD_W(WORD_W), .BANK_LO(BANK_LO),
        .BANK_W(BANK_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_LO(TAG_LO), .TAG_W(TAG_W)
    ) u_snoop_split (
        .addr(sn_addr), .word(s_word), .bank(s_bank), .idx(s_idx), .tag(s_tag)
    );

    // Bank decode and foreign-write snoop qualification.
    always_comb begin
        bank_hit          = (c_bank == MY_BANK);
        sn_en             = sn_valid && sn_we && (s_bank == MY_BANK) && !(mb_req && mb_gnt);
        unused_snoop_word = ^{s_word, c_word};
    end

    xp_tag_array #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(c_idx), .lk_tag(c_tag), .lk_hit(lk_hit),
        .sn_en(sn_en), .sn_idx(s_idx), .sn_tag(s_tag),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag)
    );

    xp_line_ram #(
        .NUM_LINES(NUM_LINES), .WORDS(WORDS_PER_LINE), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .WORD_W(WORD_W)
    ) u_data (
        .clk(clk), .wr_en(ram_we), .wr_idx(ram_widx), .wr_word(ram_wword),
        .wr_data(ram_wdata), .rd_idx(rd_idx), .rd_word(rd_word), .rd_data(rd_data)
    );

    xp_slice_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS_PER_LINE), .WORD_LO(WORD_LO),
        .WORD_W(WORD_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_LO(TAG_LO), .TAG_W(TAG_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .bank_hit(bank_hit), .lk_hit(lk_hit),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
        .mb_gnt(mb_gnt), .mb_rvalid(mb_rvalid), .mb_rdata(mb_rdata),
        .mb_req(mb_req), .mb_valid(mb_valid), .mb_we(mb_we),
        .mb_addr(mb_addr), .mb_wdata(mb_wdata),
        .ram_we(ram_we), .ram_widx(ram_widx), .ram_wword(ram_wword), .ram_wdata(ram_wdata),
        .rd_idx(rd_idx), .rd_word(rd_word),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag)
    );

    // Read data, zero outside a response.
    always_comb begin
        cpu_rdata = cpu_rvalid ? rd_data : '0;
    end

endmodule

// File: rtl/xp_cache_slice_chk.sv
// Protocol checker for the crosspoint cache slice, attached by bind.
// Assumes: same parameters as the bound instance.
module xp_cache_slice_chk #(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int WORDS_PER_LINE = 4,
    parameter int NUM_BANKS      = 4,
    parameter int BANK_ID        = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic              mb_req,
    input logic              mb_gnt,
    input logic              mb_valid,
    input logic              mb_we,
    input logic [ADDR_W-1:0] mb_addr
);

    localparam int OFF_W    = $clog2(DATA_W / 8);
    localparam int WORD_W   = $clog2(WORDS_PER_LINE);
    localparam int BANK_W   = $clog2(NUM_BANKS);
    localparam int LINE_OFF = OFF_W + WORD_W;
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

    // R3: fill address is line aligned
    a_r3_fill_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mb_valid && !mb_we |-> mb_addr[LINE_OFF-1:0] == '0);

    // R3: address cycle lasts one cycle
    a_r3_addr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mb_valid |=> !mb_valid);

    // R6: bus driven only under grant
    a_r6_drive_granted: assert property (@(posedge clk) disable iff (!rst_n)
        mb_valid |-> mb_req && mb_gnt);

    // R5: response is a single-cycle pulse
    a_r5_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);

    // R4: data returned only after the bus is released
    a_r4_resp_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> !mb_req);

    // R11: port stalled while the bus is in use
    a_r11_stall_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        mb_req |-> !cpu_ready);

    // R2: foreign-bank request leaves the slice idle
    a_r2_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_ready && (cpu_addr[OFF_W + WORD_W +: BANK_W] != MY_BANK)
        |=> cpu_ready && !mb_req && !cpu_rvalid);

endmodule

bind xp_cache_slice xp_cache_slice_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS_PER_LINE(WORDS_PER_LINE),
    .NUM_BANKS(NUM_BANKS), .BANK_ID(BANK_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .mb_req(mb_req),
    .mb_gnt(mb_gnt), .mb_valid(mb_valid), .mb_we(mb_we), .mb_addr(mb_addr)
);

// File: tb/test_xp_cache_slice.sv
// Directed bench for the crosspoint cache slice. It models the
// arbiter, the memory bank and the mirrored snoop bus.
module test_xp_cache_slice;

    localparam int BANK = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mb_req, mb_valid, mb_we;
    logic        mb_gnt = 1'b0, mb_rvalid = 1'b0;
    logic [31:0] mb_addr, mb_wdata;
    logic [31:0] mb_rdata = '0;
    logic        sn_valid = 1'b0, sn_we = 1'b0;
    logic [31:0] sn_addr = '0;

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    // Bank memory model state.
    logic [31:0] bmem [logic [31:0]];
    int          pend = 0;
    logic [31:0] fbase = '0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] lw_addr = '0, lw_data = '0, lf_addr = '0;
    logic        ext_go = 1'b0;
    logic [31:0] ext_addr = '0, ext_data = '0;

    always #5 clk = ~clk;

    xp_cache_slice #(.BANK_ID(BANK)) i_xp_cache_slice (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mb_req(mb_req),
        .mb_gnt(mb_gnt), .mb_valid(mb_valid), .mb_we(mb_we), .mb_addr(mb_addr),
        .mb_wdata(mb_wdata), .mb_rvalid(mb_rvalid), .mb_rdata(mb_rdata),
        .sn_valid(sn_valid), .sn_we(sn_we), .sn_addr(sn_addr)
    );

    function automatic logic [31:0] mem_rd(logic [31:0] a);
        if (bmem.exists(a)) return bmem[a];
        return ~a ^ 32'h1357_9BDF;
    endfunction

    // Arbiter, memory and snoop mirror, all driven at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (pend > 0) begin
                mb_rvalid = 1'b1;
                mb_rdata  = mem_rd(fbase + 32'((4 - pend) * 4));
                pend      = pend - 1;
            end else begin
                mb_rvalid = 1'b0;
            end
            mb_gnt = mb_req;
            if (mb_valid && !mb_we) begin
                pend = 4; fbase = mb_addr; lf_addr = mb_addr; rd_cnt++;
            end
            if (mb_valid && mb_we) begin
                bmem[mb_addr] = mb_wdata; lw_addr = mb_addr; lw_data = mb_wdata; wr_cnt++;
            end
            if (ext_go) begin
                sn_valid = 1'b1; sn_we = 1'b1; sn_addr = ext_addr;
                bmem[ext_addr] = ext_data; ext_go = 1'b0;
            end else begin
                sn_valid = mb_valid; sn_we = mb_we; sn_addr = mb_addr;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one read, return data, cycles to response, bus use and stall.
    task automatic do_read(input logic [31:0] a, output logic [31:0] d,
                           output int cyc, output logic bus, output logic stall_ok);
        bus = 1'b0; stall_ok = 1'b1; d = '0; cyc = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        for (int n = 1; n <= 40; n++) begin
            if (n > 1) @(negedge clk);
            if (cpu_ready) stall_ok = 1'b0;
            if (mb_req) bus = 1'b1;
            if (cpu_rvalid) begin d = cpu_rdata; cyc = n; break; end
        end
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] v, output int wc);
        int w0;
        w0 = wr_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        for (int n = 0; n < 40; n++) begin
            if (cpu_ready) break;
            @(negedge clk);
        end
        wc = wr_cnt - w0;
    endtask

    task automatic ext_write(input logic [31:0] a, input logic [31:0] v);
        @(posedge clk);
        #1;
        ext_addr = a; ext_data = v; ext_go = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [31:0] A = 32'h0003_0460;
    localparam logic [31:0] B = 32'h0005_08A0;
    localparam logic [31:0] C = A + 32'h0001_0000;

    task automatic t_reset();
        chk("R1 ready after reset", 32'(cpu_ready), 1);
        chk("R1 rvalid after reset", 32'(cpu_rvalid), 0);
        chk("R1 mb_req after reset", 32'(mb_req), 0);
    endtask

    task automatic t_read_miss_fill();
        logic [31:0] d; int c; logic b, s; int r0;
        r0 = rd_cnt;
        do_read(A + 32'h8, d, c, b, s);
        chk("R1 first read misses", 32'(b), 1);
        chk("R3 one fill address cycle", 32'(rd_cnt - r0), 1);
        chk("R3 fill address aligned", lf_addr, A);
        chk("R4 miss data word2", d, mem_rd(A + 32'h8));
        chk("R11 stalled during fill", 32'(s), 1);
        do_read(A + 32'hC, d, c, b, s);
        chk("R4 last fill beat stored word3", d, mem_rd(A + 32'hC));
        chk("R5 hit without bus", 32'(b), 0);
    endtask

    task automatic t_read_hit();
        logic [31:0] d; int c; logic b, s;
        do_read(A, d, c, b, s);
        chk("R5 hit latency", 32'(c), 1);
        chk("R4 fill beat0 stored word0", d, mem_rd(A));
    endtask

    task automatic t_write_hit();
        logic [31:0] d; int c, wc; logic b, s;
        do_write(A + 32'h4, 32'hCAFE_0001, wc);
        chk("R6 one bus write", 32'(wc), 1);
        chk("R6 write address", lw_addr, A + 32'h4);
        chk("R6 write data", lw_data, 32'hCAFE_0001);
        do_read(A + 32'h4, d, c, b, s);
        chk("R7 hit after own write", 32'(b), 0);
        chk("R7 updated data", d, 32'hCAFE_0001);
    endtask

    task automatic t_write_miss();
        logic [31:0] d; int c, wc; logic b, s;
        do_write(B + 32'h4, 32'hBEEF_0002, wc);
        chk("R6 write miss still goes to bus", 32'(wc), 1);
        do_read(B + 32'h4, d, c, b, s);
        chk("R8 no allocate on write miss", 32'(b), 1);
        chk("R8 refetched data", d, 32'hBEEF_0002);
    endtask

    task automatic t_foreign_bank();
        int r0, w0; logic seen;
        r0 = rd_cnt; w0 = wr_cnt; seen = 1'b0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h0003_0450;
        @(negedge clk);
        cpu_we = 1'b1; cpu_wdata = 32'h1111_2222;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        for (int n = 0; n < 5; n++) begin
            if (cpu_rvalid || mb_req || !cpu_ready) seen = 1'b1;
            @(negedge clk);
        end
        chk("R2 foreign bank no activity", 32'(seen), 0);
        chk("R2 foreign bank no bus cycles", 32'((rd_cnt - r0) + (wr_cnt - w0)), 0);
    endtask

    task automatic t_snoop();
        logic [31:0] d; int c; logic b, s;
        ext_write(B + 32'h0002_0000, 32'h7777_0003);
        do_read(B, d, c, b, s);
        chk("R9 other tag snoop keeps line", 32'(b), 0);
        ext_write(A + 32'h4, 32'h5555_0004);
        do_read(A + 32'h4, d, c, b, s);
        chk("R9 matching snoop invalidates", 32'(b), 1);
        chk("R9 refetch sees other writer", d, 32'h5555_0004);
    endtask

    task automatic t_conflict();
        logic [31:0] d; int c; logic b, s;
        do_read(C, d, c, b, s);
        chk("R10 same index new tag misses", 32'(b), 1);
        chk("R10 conflict data", d, mem_rd(C));
        do_read(A, d, c, b, s);
        chk("R10 evicted tag misses", 32'(b), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss_fill();
        t_read_hit();
        t_write_hit();
        t_write_miss();
        t_foreign_bank();
        t_snoop();
        t_conflict();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule